// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Controller

This block keeps a table of 128 buffer descriptors for a 10/100 Ethernet MAC. Each descriptor has two 32-bit words: a length/flags word and a buffer pointer. A programmable count N divides the table. Entries below N form the transmit ring. Entries from N up to 127 form the receive ring. The block holds the current transmit and receive indices. It decides when the current transmit descriptor may be handed to the transmitter. When a transmit or receive completes, it updates the descriptor's flags and length and then advances the ring index.

The host reaches four control words and the descriptor table through two simple write-strobe ports with combinational read data. The transmit engine sees a one-cycle start pulse that carries the descriptor index, and it answers with a completion pulse. The receive engine reports each arriving frame as a single pulse with a length. Completions raise bits in an interrupt-source word. The host clears these bits by writing ones. A single interrupt line is high while any source bit is also set in the mask word.

Control words are selected by `regAddr`: 0 is the mode word (bit 1 enables transmit, bit 0 enables receive), 1 is the interrupt source, 2 is the interrupt mask, and 3 is the transmit count N.

Top module: `ethDescRing`

## Requirements
- R1: After reset, N reads 0x40, the mode, source and mask words read 0, `txIdx` is 0, `rxIdx` is 0x40, `irq` is low, and every flags word is 0.
- R2: A write of 0x80 or more to the count word (address 3) leaves N unchanged; smaller values are stored.
- R3: When transmit is enabled, N is nonzero, no transmit is in flight, and the current descriptor has bit 15 (ready) set and a length in bits 31:16 greater than 4, `txStart` pulses for one cycle on the next clock with `txStartIdx` equal to the current index. Host table writes make a stalled descriptor eligible.
- R4: On `txDone` for the descriptor in flight, its bits 15, 8 and 7:0 are cleared. The transmit index becomes 0 if that descriptor has bit 13 (wrap) set; otherwise it increments, and it returns to 0 when it reaches N.
- R5: On `rxDone` for an empty current receive descriptor (bit 15 set), bit 15 is cleared and `rxLen` is written into bits 31:16. The receive index then returns to N if bit 13 is set or the index is 0x7F; otherwise it increments.
- R6: On `rxDone` when the current receive descriptor has bit 15 clear, the descriptor and the receive index are unchanged and source bit 4 is set.
- R7: A completion whose descriptor has bit 14 set sets source bit 0 (transmit) or bit 2 (receive); without bit 14, no source bit is set.
- R8: Writing the source word clears exactly the bits written as one. `irq` is high exactly when source AND mask is nonzero.
- R9: A write that turns transmit enable from 0 to 1 sets the transmit index to 0. A write that turns receive enable from 0 to 1 sets the receive index to N.
- R10: `rxDone` while receive is disabled, and `txDone` with no transmit in flight, change nothing.
- R11: The table uses word addresses 0 to 255. The even word 2i is the flags of descriptor i and the odd word 2i+1 is its pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Control word write strobe |
| regAddr | input | 2 | Control word select |
| regWData | input | 32 | Control word write data |
| regRData | output | 32 | Control word read data (combinational) |
| tblWe | input | 1 | Descriptor table write strobe |
| tblAddr | input | 8 | Descriptor table word address |
| tblWData | input | 32 | Descriptor table write data |
| tblRData | output | 32 | Descriptor table read data (combinational) |
| txDone | input | 1 | Transmit completion pulse |
| rxDone | input | 1 | Frame arrival pulse |
| rxLen | input | 16 | Length of the arriving frame |
| txStart | output | 1 | One-cycle transmit start pulse |
| txStartIdx | output | 7 | Descriptor index of the started transmit |
| txIdx | output | 7 | Current transmit descriptor index |
| rxIdx | output | 7 | Current receive descriptor index |
| irq | output | 1 | Interrupt line |

## Verification
The transmit path is tried with several descriptors. One has a length of exactly 4 and must stall; raising its length with a table write must then release it, which separates the strict length bound from an inclusive one. Other descriptors advance the index by increment, by reaching N, or by the wrap bit, and the test uses N values chosen so that each of these gives a different index. The receive path is tried with an empty descriptor, a full descriptor that must produce a busy event, a wrap-bit descriptor, and the pair 0x7E/0x7F under N = 0x7E, which tells the top-of-table return apart from a plain increment. Completions with no transmit in flight, or with receive disabled, check that stray pulses leave the state unchanged.

// File: rtl/ringPkg.sv
package ringPkg;
  localparam int DESC_NUM = 128;
  localparam int IDX_W    = $clog2(DESC_NUM);
  localparam int CNT_W    = IDX_W + 1;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;

  localparam int READY_BIT = 15;
  localparam int IRQ_BIT   = 14;
  localparam int WRAP_BIT  = 13;
  localparam int STAT_BIT  = 8;
  localparam int STAT_LOW  = 8;

  localparam int SRC_TX   = 0;
  localparam int SRC_RX   = 2;
  localparam int SRC_BUSY = 4;

  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_SRC   = 2'd1;
  localparam logic [1:0] REG_MASK  = 2'd2;
  localparam logic [1:0] REG_COUNT = 2'd3;

  typedef struct packed {
    logic             txFinish;
    logic             rxFinish;
    logic             rxNoRoom;
    logic [IDX_W-1:0] txSlot;
    logic [IDX_W-1:0] rxSlot;
    logic [LEN_W-1:0] rxLen;
  } ringStrobeT;
endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [WORD_W-1:0] regWData,
  input  logic              txDoneIn,
  input  logic              rxDoneIn,
  input  logic [LEN_W-1:0]  rxLenIn,
  input  logic [WORD_W-1:0] txFlags,
  input  logic [WORD_W-1:0] rxFlags,
  output ringStrobeT        strobe,
  output logic [IDX_W-1:0]  txLookIdx,
  output logic [IDX_W-1:0]  txIdx,
  output logic [IDX_W-1:0]  rxIdx,
  output logic [CNT_W-1:0]  txCount,
  output logic              txEn,
  output logic              rxEn,
  output logic              txBusy,
  output logic              txStart,
  output logic [IDX_W-1:0]  txStartIdx
);
  localparam logic [CNT_W-1:0] COUNT_LIMIT = CNT_W'(DESC_NUM);
  localparam logic [CNT_W-1:0] COUNT_RESET = CNT_W'(DESC_NUM / 2);
  localparam logic [LEN_W-1:0] MIN_TX_LEN  = LEN_W'(4);

  logic             modeWr, countWr, txRise, rxRise, canStart, rxTake;
  logic [CNT_W-1:0] txIdxInc;
  logic [IDX_W-1:0] txIdxNext, rxIdxNext;

  assign modeWr  = regWe && (regAddr == REG_MODE);
  assign countWr = regWe && (regAddr == REG_COUNT) && (regWData < WORD_W'(COUNT_LIMIT));
  assign txRise  = modeWr && regWData[1] && !txEn;
  assign rxRise  = modeWr && regWData[0] && !rxEn;
  assign rxTake  = rxDoneIn && rxEn;

  assign canStart = txEn && (txCount != '0) && !txBusy && txFlags[READY_BIT]
                    && (txFlags[WORD_W-1 -: LEN_W] > MIN_TX_LEN);

  assign txLookIdx = txBusy ? txStartIdx : txIdx;

  always_comb begin
    strobe.txFinish = txDoneIn && txBusy;
    strobe.rxFinish = rxTake && rxFlags[READY_BIT];
    strobe.rxNoRoom = rxTake && !rxFlags[READY_BIT];
    strobe.txSlot   = txStartIdx;
    strobe.rxSlot   = rxIdx;
    strobe.rxLen    = rxLenIn;
  end

  assign txIdxInc  = CNT_W'(txStartIdx) + CNT_W'(1);
  assign txIdxNext = (txFlags[WRAP_BIT] || txIdxInc >= txCount) ? '0 : txIdxInc[IDX_W-1:0];
  assign rxIdxNext = (rxFlags[WRAP_BIT] || rxIdx == '1) ? txCount[IDX_W-1:0]
                                                        : rxIdx + IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn       <= 1'b0;
      rxEn       <= 1'b0;
      txCount    <= COUNT_RESET;
      txIdx      <= '0;
      rxIdx      <= COUNT_RESET[IDX_W-1:0];
      txBusy     <= 1'b0;
      txStart    <= 1'b0;
      txStartIdx <= '0;
    end else begin
      if (modeWr) begin
        txEn <= regWData[1];
        rxEn <= regWData[0];
      end
      if (countWr) txCount <= regWData[CNT_W-1:0];
      txStart <= canStart;
      if (canStart) begin
        txBusy     <= 1'b1;
        txStartIdx <= txIdx;
      end else if (strobe.txFinish) begin
        txBusy <= 1'b0;
        txIdx  <= txIdxNext;
      end
      if (txRise) txIdx <= '0;
      if (strobe.rxFinish) rxIdx <= rxIdxNext;
      if (rxRise) rxIdx <= txCount[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/ringData.sv
module ringData
  import ringPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWe,
  input  logic [IDX_W:0]    tblAddr,
  input  logic [WORD_W-1:0] tblWData,
  output logic [WORD_W-1:0] tblRData,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [WORD_W-1:0] regWData,
  input  ringStrobeT        strobe,
  input  logic [IDX_W-1:0]  txLookIdx,
  input  logic [IDX_W-1:0]  rxIdx,
  output logic [WORD_W-1:0] txFlags,
  output logic [WORD_W-1:0] rxFlags,
  output logic [WORD_W-1:0] intSrc,
  output logic [WORD_W-1:0] intMask,
  output logic              irq
);
  localparam logic [WORD_W-1:0] TX_CLEAR = (WORD_W'(1) << READY_BIT) | (WORD_W'(1) << STAT_BIT)
                                         | ((WORD_W'(1) << STAT_LOW) - WORD_W'(1));
  localparam logic [LEN_W-1:0]  RX_CLEAR = LEN_W'(1) << READY_BIT;

  logic [WORD_W-1:0] flagMem [DESC_NUM];
  logic [WORD_W-1:0] ptrMem  [DESC_NUM];
  logic [IDX_W-1:0]  hostIdx;
  logic              hostFlagWr, hostPtrWr;
  logic [WORD_W-1:0] setBits, clrBits;

  assign hostIdx    = tblAddr[IDX_W:1];
  assign hostFlagWr = tblWe && !tblAddr[0];
  assign hostPtrWr  = tblWe && tblAddr[0];

  assign tblRData = tblAddr[0] ? ptrMem[hostIdx] : flagMem[hostIdx];
  assign txFlags  = flagMem[txLookIdx];
  assign rxFlags  = flagMem[rxIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DESC_NUM; e++) flagMem[e] <= '0;
    end else begin
      for (int e = 0; e < DESC_NUM; e++) begin
        if (hostFlagWr && hostIdx == IDX_W'(e)) flagMem[e] <= tblWData;
        if (strobe.txFinish && strobe.txSlot == IDX_W'(e))
          flagMem[e] <= flagMem[e] & ~TX_CLEAR;
        if (strobe.rxFinish && strobe.rxSlot == IDX_W'(e))
          flagMem[e] <= {strobe.rxLen, flagMem[e][LEN_W-1:0] & ~RX_CLEAR};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hostPtrWr) ptrMem[hostIdx] <= tblWData;
  end

  always_comb begin
    setBits           = '0;
    setBits[SRC_TX]   = strobe.txFinish && txFlags[IRQ_BIT];
    setBits[SRC_RX]   = strobe.rxFinish && rxFlags[IRQ_BIT];
    setBits[SRC_BUSY] = strobe.rxNoRoom;
    clrBits           = (regWe && regAddr == REG_SRC) ? regWData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intSrc  <= '0;
      intMask <= '0;
    end else begin
      intSrc <= (intSrc & ~clrBits) | setBits;
      if (regWe && regAddr == REG_MASK) intMask <= regWData;
    end
  end

  assign irq = |(intSrc & intMask);
endmodule

// File: rtl/ethDescRing.sv
module ethDescRing
  import ringPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [WORD_W-1:0] regWData,
  output logic [WORD_W-1:0] regRData,
  input  logic              tblWe,
  input  logic [IDX_W:0]    tblAddr,
  input  logic [WORD_W-1:0] tblWData,
  output logic [WORD_W-1:0] tblRData,
  input  logic              txDone,
  input  logic              rxDone,
  input  logic [LEN_W-1:0]  rxLen,
  output logic              txStart,
  output logic [IDX_W-1:0]  txStartIdx,
  output logic [IDX_W-1:0]  txIdx,
  output logic [IDX_W-1:0]  rxIdx,
  output logic              irq
);
  ringStrobeT        strobe;
  logic [IDX_W-1:0]  txLookIdx;
  logic [CNT_W-1:0]  txCount;
  logic              txEn, rxEn, txBusy;
  logic [WORD_W-1:0] txFlags, rxFlags, intSrc, intMask;

  ringCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWData(regWData),
    .txDoneIn(txDone), .rxDoneIn(rxDone), .rxLenIn(rxLen),
    .txFlags(txFlags), .rxFlags(rxFlags), .strobe(strobe), .txLookIdx(txLookIdx),
    .txIdx(txIdx), .rxIdx(rxIdx), .txCount(txCount), .txEn(txEn), .rxEn(rxEn),
    .txBusy(txBusy), .txStart(txStart), .txStartIdx(txStartIdx)
  );

  ringData u_data (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr), .tblWData(tblWData),
    .tblRData(tblRData), .regWe(regWe), .regAddr(regAddr), .regWData(regWData),
    .strobe(strobe), .txLookIdx(txLookIdx), .rxIdx(rxIdx), .txFlags(txFlags),
    .rxFlags(rxFlags), .intSrc(intSrc), .intMask(intMask), .irq(irq)
  );

  always_comb begin
    unique case (regAddr)
      REG_MODE:  regRData = {{(WORD_W-2){1'b0}}, txEn, rxEn};
      REG_SRC:   regRData = intSrc;
      REG_MASK:  regRData = intMask;
      default:   regRData = WORD_W'(txCount);
    endcase
  end
endmodule

// File: rtl/ringChecker.sv
module ringChecker
  import ringPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              txStart,
  input logic              txEn,
  input logic              txBusy,
  input logic              txFinish,
  input logic              rxDone,
  input logic              rxEn,
  input logic [WORD_W-1:0] rxFlags,
  input logic [CNT_W-1:0]  txCount,
  input logic [WORD_W-1:0] intSrc,
  input logic              irq
);
  // R3: the start strobe lasts one cycle only
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R3: a start follows a cycle with transmit enabled
  a_r3_start_enabled: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(txEn));

  // R4: a finished transmit frees the transmitter
  a_r4_finish_frees: assert property (@(posedge clk) disable iff (!rstN)
    txFinish |=> !txBusy);

  // R6: a frame meeting a full descriptor raises the busy source bit
  a_r6_busy_source: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxEn && !rxFlags[READY_BIT]) |=> intSrc[SRC_BUSY]);

  // R2: the transmit count never reaches the table size
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    txCount < CNT_W'(DESC_NUM));

  // R8: without a host write or a completion the line holds
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!regWe && !txFinish && !rxDone) |=> $stable(irq));
endmodule

bind ethDescRing ringChecker u_ringChecker (
  .clk(clk), .rstN(rstN), .regWe(regWe), .txStart(txStart), .txEn(txEn),
  .txBusy(txBusy), .txFinish(strobe.txFinish), .rxDone(rxDone), .rxEn(rxEn),
  .rxFlags(rxFlags), .txCount(txCount), .intSrc(intSrc), .irq(irq)
);

// File: tb/test_ethDescRing.sv
module test_ethDescRing;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        tblWe = 1'b0;
  logic [7:0]  tblAddr = '0;
  logic [31:0] tblWData = '0;
  logic [31:0] tblRData;
  logic        txDone = 1'b0;
  logic        rxDone = 1'b0;
  logic [15:0] rxLen = '0;
  logic        txStart;
  logic [6:0]  txStartIdx, txIdx, rxIdx;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int startCount = 0;
  int lastStartIdx = -1;
  bit simDone = 0;

  // behavioural reference state
  bit [31:0] mFlags [128];
  int  mN, mTx, mRx, mFly;
  bit  mTxEn, mRxEn, mBusy, expStart;
  int  expIdx;
  bit [31:0] mSrc, mMask;

  always #10 clk = ~clk;

  ethDescRing i_ethDescRing (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .tblWe(tblWe), .tblAddr(tblAddr), .tblWData(tblWData),
    .tblRData(tblRData), .txDone(txDone), .rxDone(rxDone), .rxLen(rxLen),
    .txStart(txStart), .txStartIdx(txStartIdx), .txIdx(txIdx), .rxIdx(rxIdx), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    foreach (mFlags[i]) mFlags[i] = '0;
    mN = 64; mTx = 0; mRx = 64; mFly = 0;
    mTxEn = 0; mRxEn = 0; mBusy = 0; expStart = 0; expIdx = 0;
    mSrc = '0; mMask = '0;
  endtask

  task automatic modelStep();
    bit can, tfin, racc, rok, rfull;
    bit [31:0] setB, clrB, txNew, rxNew;
    int nTx, nRx, n;
    bit [31:0] ff, rf;
    ff = mFlags[mFly];
    rf = mFlags[mRx];
    can   = mTxEn && mN != 0 && !mBusy && mFlags[mTx][15] && mFlags[mTx][31:16] > 4;
    tfin  = txDone && mBusy;
    racc  = rxDone && mRxEn;
    rok   = racc && rf[15];
    rfull = racc && !rf[15];
    setB = '0;
    if (tfin && ff[14]) setB[0] = 1;
    if (rok && rf[14]) setB[2] = 1;
    if (rfull) setB[4] = 1;
    clrB = (regWe && regAddr == 2'd1) ? regWData : '0;
    nTx = mTx; nRx = mRx;
    if (tfin) begin
      n = mFly + 1;
      nTx = (ff[13] || n >= mN) ? 0 : n;
    end
    if (rok) nRx = (rf[13] || mRx == 127) ? mN : mRx + 1;
    txNew = ff & ~32'h0000_81FF;
    rxNew = {rxLen, rf[15:0] & 16'h7FFF};
    if (tblWe && !tblAddr[0]) mFlags[tblAddr[7:1]] = tblWData;
    if (tfin) mFlags[mFly] = txNew;
    if (rok) mFlags[mRx] = rxNew;
    mSrc = (mSrc & ~clrB) | setB;
    expStart = can;
    if (can) begin mBusy = 1; mFly = mTx; expIdx = mTx; end
    else if (tfin) mBusy = 0;
    if (regWe && regAddr == 2'd0) begin
      if (regWData[1] && !mTxEn) nTx = 0;
      if (regWData[0] && !mRxEn) nRx = mN;
    end
    mTx = nTx; mRx = nRx;
    if (regWe && regAddr == 2'd0) begin mTxEn = regWData[1]; mRxEn = regWData[0]; end
    if (regWe && regAddr == 2'd2) mMask = regWData;
    if (regWe && regAddr == 2'd3 && regWData < 32'h80) mN = int'(regWData);
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else modelStep();
  end

  // per-cycle comparison against the reference (R3 R4 R5 R8 R9)
  always @(negedge clk) begin
    if (rstN && !simDone) begin
      check(txStart == expStart, "R3 cycle txStart", txStart, expStart);
      if (expStart) check(txStartIdx == 7'(expIdx), "R3 cycle txStartIdx", txStartIdx, expIdx);
      check(txIdx == 7'(mTx), "R4/R9 cycle txIdx", txIdx, mTx);
      check(rxIdx == 7'(mRx), "R5/R9 cycle rxIdx", rxIdx, mRx);
      check(irq == |(mSrc & mMask), "R8 cycle irq", irq, |(mSrc & mMask));
      if (txStart) begin startCount++; lastStartIdx = int'(txStartIdx); end
    end
  end

  task automatic regW(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWData = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic tblW(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); tblWe = 1; tblAddr = a; tblWData = d;
    @(negedge clk); tblWe = 0;
  endtask

  task automatic pulseTx();
    @(negedge clk); txDone = 1;
    @(negedge clk); txDone = 0;
  endtask

  task automatic pulseRx(input logic [15:0] len);
    @(negedge clk); rxDone = 1; rxLen = len;
    @(negedge clk); rxDone = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkReg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    regAddr = a; #1;
    check(regRData == exp, tag, regRData, exp);
  endtask

  task automatic chkTbl(input logic [7:0] a, input logic [31:0] exp, input string tag);
    tblAddr = a; #1;
    check(tblRData == exp, tag, tblRData, exp);
  endtask

  task automatic chkVal(input longint act, input longint exp, input string tag);
    #1; check(act == exp, tag, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chkReg(2'd3, 32'h40, "R1 count reset");
    chkReg(2'd0, 32'h0, "R1 mode reset");
    chkReg(2'd1, 32'h0, "R1 source reset");
    chkReg(2'd2, 32'h0, "R1 mask reset");
    chkVal(txIdx, 0, "R1 txIdx reset");
    chkVal(rxIdx, 7'h40, "R1 rxIdx reset");
    chkVal(irq, 0, "R1 irq reset");
    chkTbl(8'd6, 32'h0, "R1 flags reset");
    // R2 count filtering
    regW(2'd3, 32'h80);
    chkReg(2'd3, 32'h40, "R2 write 0x80 ignored");
    regW(2'd3, 32'h1FF);
    chkReg(2'd3, 32'h40, "R2 write 0x1FF ignored");
    regW(2'd3, 32'h2);
    chkReg(2'd3, 32'h2, "R2 write 2 stored");
    // R11 addressing
    tblW(8'd0, 32'h003C_C1FF);
    tblW(8'd1, 32'h1234_5678);
    chkTbl(8'd0, 32'h003C_C1FF, "R11 even word flags");
    chkTbl(8'd1, 32'h1234_5678, "R11 odd word pointer");
    idle(3);
    chkVal(startCount, 0, "R3 no start while disabled");
    // R3 start
    regW(2'd2, 32'h1);
    regW(2'd0, 32'h2);
    idle(2);
    chkVal(startCount, 1, "R3 start after enable");
    chkVal(lastStartIdx, 0, "R3 start index 0");
    // R4 / R7 / R8 completion
    pulseTx();
    chkTbl(8'd0, 32'h003C_4000, "R4 tx flags cleared");
    chkReg(2'd1, 32'h1, "R7 tx source bit");
    chkVal(irq, 1, "R8 irq on masked source");
    chkVal(txIdx, 1, "R4 tx index increment");
    // R3 length bound
    tblW(8'd2, 32'h0004_8000);
    idle(3);
    chkVal(startCount, 1, "R3 length 4 stalls");
    tblW(8'd2, 32'h0005_8000);
    idle(2);
    chkVal(startCount, 2, "R3 table write releases");
    chkVal(lastStartIdx, 1, "R3 start index 1");
    pulseTx();
    chkVal(txIdx, 0, "R4 tx index returns at N");
    chkTbl(8'd2, 32'h0005_0000, "R4 tx flags cleared no irq");
    chkReg(2'd1, 32'h1, "R7 no source without irq bit");
    // R8 write-one-to-clear
    regW(2'd1, 32'hFFFF_FFFE);
    chkReg(2'd1, 32'h1, "R8 zero bits kept");
    regW(2'd1, 32'h1);
    chkReg(2'd1, 32'h0, "R8 one bit cleared");
    chkVal(irq, 0, "R8 irq drops");
    // R10 stray txDone
    pulseTx();
    chkVal(txIdx, 0, "R10 stray txDone index");
    chkTbl(8'd0, 32'h003C_4000, "R10 stray txDone flags");
    chkReg(2'd1, 32'h0, "R10 stray txDone source");
    // R4 wrap bit
    regW(2'd3, 32'h4);
    tblW(8'd0, 32'h000A_A000);
    idle(2);
    chkVal(startCount, 3, "R3 third start");
    pulseTx();
    chkVal(txIdx, 0, "R4 wrap bit to 0");
    // R9 tx rising edge
    tblW(8'd0, 32'h000A_8000);
    idle(2);
    pulseTx();
    chkVal(txIdx, 1, "R4 index 1 before toggle");
    regW(2'd0, 32'h0);
    regW(2'd0, 32'h2);
    chkVal(txIdx, 0, "R9 tx enable edge resets");
    // R9 rx rising edge, R5 / R7
    regW(2'd0, 32'h3);
    chkVal(rxIdx, 4, "R9 rx enable edge to N");
    tblW(8'd8, 32'h0000_C000);
    regW(2'd2, 32'h5);
    pulseRx(16'd100);
    chkTbl(8'd8, 32'h0064_4000, "R5 rx flags and length");
    chkVal(rxIdx, 5, "R5 rx increment");
    chkReg(2'd1, 32'h4, "R7 rx source bit");
    chkVal(irq, 1, "R8 irq rx");
    // R6 busy
    pulseRx(16'd50);
    chkReg(2'd1, 32'h14, "R6 busy bit");
    chkVal(rxIdx, 5, "R6 index held");
    chkTbl(8'd10, 32'h0, "R6 descriptor untouched");
    regW(2'd1, 32'h14);
    // R5 wrap bit
    tblW(8'd10, 32'h0000_A000);
    pulseRx(16'd7);
    chkVal(rxIdx, 4, "R5 wrap bit to N");
    chkTbl(8'd10, 32'h0007_2000, "R5 wrap flags");
    chkReg(2'd1, 32'h0, "R7 rx no irq bit");
    // R5 top of table
    regW(2'd3, 32'h7E);
    regW(2'd0, 32'h2);
    regW(2'd0, 32'h3);
    chkVal(rxIdx, 7'h7E, "R9 rx edge to 0x7E");
    tblW(8'd252, 32'h0000_8000);
    tblW(8'd254, 32'h0000_8000);
    pulseRx(16'd60);
    chkVal(rxIdx, 7'h7F, "R5 increment to 0x7F");
    pulseRx(16'd61);
    chkVal(rxIdx, 7'h7E, "R5 0x7F returns to N");
    chkTbl(8'd254, 32'h003D_0000, "R5 top descriptor flags");
    // R10 rx disabled
    regW(2'd0, 32'h2);
    tblW(8'd252, 32'h0000_8000);
    pulseRx(16'd9);
    chkTbl(8'd252, 32'h0000_8000, "R10 rx disabled flags");
    chkVal(rxIdx, 7'h7E, "R10 rx disabled index");
    chkReg(2'd1, 32'h0, "R10 rx disabled source");
    // R11 last pointer
    tblW(8'd255, 32'hDEAD_BEEF);
    chkTbl(8'd255, 32'hDEAD_BEEF, "R11 last pointer word");
    idle(2);
    simDone = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!simDone) begin
      simDone = 1;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule